// File: doc/BRIEF.md
# Command-Driven NOR Flash Model

This block behaves like one NOR flash device that is driven by command codes over a simple synchronous bus. A small register array holds the contents. While the block is idle, a read strobe returns the stored word at the given address. A write strobe is taken as a command, and only its low byte is decoded. Commands move a mode state machine through these operations: single-word program, buffered program (opcode, then word count, then data words, then confirm code), block erase (opcode, then confirm code), status read, status clear and identifier read. Program and erase take effect at once, so the device always reports ready.

A parameter selects byte mode (8-bit data) or word mode (16-bit data). In word mode the lowest bus address bit is dropped, so a device word sits at the bus byte address shifted right by one. Read data is registered. It appears in the cycle after the read strobe, and the bus mode at that strobe decides whether the word comes from the array, is the ready status or is an identifier code. An unknown opcode raises a one-cycle error flag and leaves the mode unchanged.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the block is in array mode, every array word reads as all ones and `cmd_err` is low.
- R2: In the modes that accept commands (array, identifier, program-done, erase-done), a write is decoded from `bus_wdata[7:0]` alone. Upper data bits have no effect.
- R3: Opcode 0x40 or 0x10 arms a single program. A read while the program is armed returns 0. The next write stores its data at its address and enters program-done mode. There, reads return 0x0080 and the next write is decoded as a command.
- R4: Opcode 0xE8 latches the write's address as the buffer base. The next write sets the word count to `bus_wdata[4:0]` + 1 (1 to 32).
- R5: In the buffer data phase, a write is buffered only if its address lies in [base, base+count-1]. Any other write is dropped and does not count. After count buffered writes the block enters the confirm phase.
- R6: In the confirm phase, a write with low byte 0xD0 stores buffer word i at base+i for every i < count. Any other write discards the buffer. Either way the block returns to array mode.
- R7: Opcode 0x20 arms an erase. A following write with low byte 0xD0 sets to all ones every word of the block that contains that address, with the start aligned down to a multiple of 2^BLK_W. The block then enters erase-done mode, where the next write is decoded as a command. Words outside that block are unchanged.
- R8: While an erase is armed, a write whose low byte is not 0xD0 is ignored and the erase stays armed.
- R9: After opcode 0x70, the next access returns the block to array mode. If that access is a read it returns 0x0080. If it is a write it is not decoded.
- R10: Opcodes 0x50 and 0xFF return the block to array mode.
- R11: After opcode 0x90, reads at device address 0 return 0x0089, reads at address 1 return DEV_CODE, and reads at any other address return 0. A write in this mode is decoded as a command.
- R12: With WORD_MODE=1, device address = bus_addr >> 1, so bus addresses 2k and 2k+1 reach the same word.
- R13: An unknown opcode leaves the mode unchanged and drives `cmd_err` high for exactly the one cycle after the write.
- R14: Reads in the buffer count, buffer data, buffer confirm, erase-armed and erase-done modes return 0x0080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Bus byte address |
| bus_wdata | input | DW | Write data or opcode |
| bus_rdata | output | DW | Read data, valid the cycle after a read strobe |
| cmd_err | output | 1 | One-cycle flag for an unknown opcode |

## Verification
The hardest case to reach is a buffered program whose data writes arrive out of order and mixed with writes outside the window. The count must drop only for in-window writes, and the confirm phase must begin exactly at the last of them. The stimulus opens a four-word buffer and writes outside the window first. It then fills the slots in shuffled order and reads the ready status between the writes. Both the committed words and the untouched out-of-window word are read back afterwards. A second buffer, discarded with a non-confirm code, shows that nothing reaches the array.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [3:0] {
    M_ARRAY, M_ID, M_STATUS, M_PROG, M_PROG_DONE,
    M_BUF_CNT, M_BUF_DATA, M_BUF_CONF, M_ERASE, M_ERASE_DONE
  } mode_t;

  localparam logic [7:0] OP_PROG_A  = 8'h40;
  localparam logic [7:0] OP_PROG_B  = 8'h10;
  localparam logic [7:0] OP_BUFFER  = 8'hE8;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] READY_CODE = 8'h80;
  localparam logic [7:0] MFR_CODE   = 8'h89;

  function automatic logic reports_ready(mode_t m);
    return (m == M_STATUS) || (m == M_PROG_DONE) || (m == M_BUF_CNT) ||
           (m == M_BUF_DATA) || (m == M_BUF_CONF) || (m == M_ERASE) ||
           (m == M_ERASE_DONE);
  endfunction
endpackage

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
  import nfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       acc_we,
  input  logic [7:0] op,
  input  logic       buf_in_win,
  input  logic       buf_last,
  output mode_t      mode,
  output logic       ev_prog,
  output logic       ev_buf_open,
  output logic       ev_buf_size,
  output logic       ev_buf_store,
  output logic       ev_commit,
  output logic       ev_erase,
  output logic       cmd_err
);
  mode_t nxt;
  logic  bad_op;

  always_comb begin
    nxt          = mode;
    bad_op       = 1'b0;
    ev_prog      = 1'b0;
    ev_buf_open  = 1'b0;
    ev_buf_size  = 1'b0;
    ev_buf_store = 1'b0;
    ev_commit    = 1'b0;
    ev_erase     = 1'b0;
    if (acc_en) begin
      unique case (mode)
        M_ARRAY, M_ID, M_PROG_DONE, M_ERASE_DONE: begin
          if (acc_we) begin
            unique case (op)
              OP_PROG_A, OP_PROG_B: nxt = M_PROG;
              OP_BUFFER: begin nxt = M_BUF_CNT; ev_buf_open = 1'b1; end
              OP_STATUS: nxt = M_STATUS;
              OP_CLEAR, OP_ARRAY: nxt = M_ARRAY;
              OP_IDENT: nxt = M_ID;
              OP_ERASE: nxt = M_ERASE;
              default: bad_op = 1'b1;
            endcase
          end
        end
        M_STATUS: nxt = M_ARRAY;
        M_PROG: if (acc_we) begin ev_prog = 1'b1; nxt = M_PROG_DONE; end
        M_BUF_CNT: if (acc_we) begin ev_buf_size = 1'b1; nxt = M_BUF_DATA; end
        M_BUF_DATA: if (acc_we && buf_in_win) begin
          ev_buf_store = 1'b1;
          if (buf_last) nxt = M_BUF_CONF;
        end
        M_BUF_CONF: if (acc_we) begin
          ev_commit = (op == OP_CONFIRM);
          nxt = M_ARRAY;
        end
        M_ERASE: if (acc_we && op == OP_CONFIRM) begin
          ev_erase = 1'b1;
          nxt = M_ERASE_DONE;
        end
        default: nxt = M_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= M_ARRAY;
      cmd_err <= 1'b0;
    end else begin
      mode    <= nxt;
      cmd_err <= bad_op;
    end
  end
endmodule

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
  parameter int AW = 9,
  parameter int DW = 16,
  parameter int CW = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      open,
  input  logic                      size,
  input  logic                      store,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic [AW-1:0]             base,
  output logic [CW:0]               count,
  output logic [CW:0]               remain,
  output logic                      in_win,
  output logic                      last,
  output logic [(1<<CW)-1:0][DW-1:0] words
);
  function automatic logic window_hit(logic [AW-1:0] a, logic [AW-1:0] b, logic [CW:0] n);
    logic [AW:0] lo, hi, x;
    lo = {1'b0, b};
    hi = lo + (AW+1)'(n);
    x  = {1'b0, a};
    return (x >= lo) && (x < hi);
  endfunction

  function automatic logic [CW-1:0] slot_of(logic [AW-1:0] a, logic [AW-1:0] b);
    return CW'(a - b);
  endfunction

  assign in_win = window_hit(addr, base, count);
  assign last   = (remain == (CW+1)'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base   <= '0;
      count  <= '0;
      remain <= '0;
    end else if (open) begin
      base   <= addr;
      count  <= '0;
      remain <= '0;
    end else if (size) begin
      count  <= {1'b0, wdata[CW-1:0]} + (CW+1)'(1);
      remain <= {1'b0, wdata[CW-1:0]} + (CW+1)'(1);
    end else if (store) begin
      remain <= remain - (CW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (store) words[slot_of(addr, base)] <= wdata;
  end
endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int AW    = 9,
  parameter int DW    = 16,
  parameter int BLK_W = 8,
  parameter int CW    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       prog,
  input  logic                       erase,
  input  logic                       commit,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  input  logic [AW-1:0]              base,
  input  logic [CW:0]                count,
  input  logic [(1<<CW)-1:0][DW-1:0] words,
  output logic [DW-1:0]              rd_word
);
  localparam int DEPTH = 1 << AW;
  localparam int NBUF  = 1 << CW;

  logic [DW-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] block_start(logic [AW-1:0] a);
    return {a[AW-1:BLK_W], BLK_W'(0)};
  endfunction

  function automatic logic [AW:0] slot_target(logic [AW-1:0] b, int j);
    return {1'b0, b} + (AW+1)'(j);
  endfunction

  assign rd_word = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (prog) mem[addr] <= wdata;
      if (erase) begin
        for (int i = 0; i < DEPTH; i++)
          if (block_start(AW'(i)) == block_start(addr)) mem[i] <= '1;
      end
      if (commit) begin
        for (int j = 0; j < NBUF; j++)
          if ((CW+1)'(j) < count && !slot_target(base, j)[AW])
            mem[slot_target(base, j)[AW-1:0]] <= words[j];
      end
    end
  end
endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nfc_pkg::*;
#(
  parameter int          WORD_MODE = 1,
  parameter int          BUS_AW    = 10,
  parameter int          BLK_W     = 8,
  parameter int          CW        = 5,
  parameter logic [7:0]  DEV_CODE  = 8'hA0,
  localparam int         DW        = WORD_MODE ? 16 : 8,
  localparam int         AW        = BUS_AW - WORD_MODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              cmd_err
);
  mode_t                      mode;
  logic [AW-1:0]              dev_addr;
  logic                       ev_prog, ev_buf_open, ev_buf_size, ev_buf_store, ev_commit, ev_erase;
  logic [AW-1:0]              buf_base;
  logic [CW:0]                buf_count, buf_remain;
  logic                       buf_in_win, buf_last;
  logic [(1<<CW)-1:0][DW-1:0] buf_words;
  logic [DW-1:0]              rd_word;
  logic [DW-1:0]              rd_next;

  generate
    if (WORD_MODE != 0) begin : g_word
      logic lsb_unused;
      assign lsb_unused = bus_addr[0];
      assign dev_addr   = bus_addr[BUS_AW-1:1];
    end else begin : g_byte
      assign dev_addr = bus_addr;
    end
  endgenerate

  flash_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .acc_en(bus_en), .acc_we(bus_we), .op(bus_wdata[7:0]),
    .buf_in_win(buf_in_win), .buf_last(buf_last), .mode(mode),
    .ev_prog(ev_prog), .ev_buf_open(ev_buf_open), .ev_buf_size(ev_buf_size),
    .ev_buf_store(ev_buf_store), .ev_commit(ev_commit), .ev_erase(ev_erase),
    .cmd_err(cmd_err)
  );

  flash_wbuf #(.AW(AW), .DW(DW), .CW(CW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .open(ev_buf_open), .size(ev_buf_size), .store(ev_buf_store),
    .addr(dev_addr), .wdata(bus_wdata), .base(buf_base), .count(buf_count),
    .remain(buf_remain), .in_win(buf_in_win), .last(buf_last), .words(buf_words)
  );

  flash_store #(.AW(AW), .DW(DW), .BLK_W(BLK_W), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .prog(ev_prog), .erase(ev_erase), .commit(ev_commit),
    .addr(dev_addr), .wdata(bus_wdata), .base(buf_base), .count(buf_count),
    .words(buf_words), .rd_word(rd_word)
  );

  always_comb begin
    if (mode == M_ARRAY)
      rd_next = rd_word;
    else if (mode == M_ID)
      rd_next = (dev_addr == AW'(0)) ? DW'(MFR_CODE) :
                (dev_addr == AW'(1)) ? DW'(DEV_CODE) : '0;
    else if (reports_ready(mode))
      rd_next = DW'(READY_CODE);
    else
      rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/nor_cmd_flash_chk.sv
module nor_cmd_flash_chk
  import nfc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          cmd_err,
  input mode_t         mode,
  input logic [CW:0]   remain,
  input logic [CW:0]   count
);
  a_r13_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(bus_en && bus_we));

  a_r13_err_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $stable(mode));

  a_r9_status_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STATUS && bus_en) |=> mode == M_ARRAY);

  a_r6_confirm_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BUF_CONF && bus_en && bus_we) |=> mode == M_ARRAY);

  a_r8_erase_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && bus_en && bus_we && bus_wdata[7:0] != OP_CONFIRM) |=> mode == M_ERASE);

  a_r14_ready_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && (mode == M_BUF_CNT || mode == M_BUF_DATA || mode == M_BUF_CONF ||
      mode == M_ERASE || mode == M_ERASE_DONE)) |=> bus_rdata == DW'(READY_CODE));

  a_r5_remain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_BUF_DATA |-> (remain <= count && remain != '0));
endmodule

bind nor_cmd_flash nor_cmd_flash_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .cmd_err(cmd_err), .mode(mode), .remain(buf_remain), .count(buf_count)
);

// File: tb/nor_cmd_flash_bench.sv
module nor_cmd_flash_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cmd_err;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic err_seen, err_after;

  always #4 clk = ~clk;

  nor_cmd_flash u_nor_cmd_flash (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_err(cmd_err)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // word-addressed write: bus byte address = 2*w (+lsb)
  task automatic wr(int w, logic [15:0] d, logic lsb = 1'b0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 10'(w * 2) | 10'(lsb); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    err_seen = cmd_err;
    @(negedge clk);
    err_after = cmd_err;
  endtask

  task automatic rd(int w, output logic [15:0] d, input logic lsb = 1'b0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 10'(w * 2) | 10'(lsb);
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 cmd_err idle", {15'b0, cmd_err}, 16'h0);
    rd(0, v);   check("R1 erased word 0", v, 16'hFFFF);
    rd(511, v); check("R1 erased word 511", v, 16'hFFFF);
  endtask

  task automatic t_program();
    logic [15:0] v;
    wr(5, 16'h0040);
    rd(5, v); check("R3 read while armed", v, 16'h0000);
    wr(5, 16'h1234);
    rd(5, v); check("R3 program-done status", v, 16'h0080);
    wr(0, 16'h00FF);
    rd(5, v); check("R3 programmed word", v, 16'h1234);
    wr(6, 16'hAB10);  // upper byte must not matter
    wr(6, 16'h5678);
    rd(0, v); check("R2 opcode 0x10 with upper bits", v, 16'h0080);
    wr(0, 16'h0090);  // decoded in program-done
    rd(0, v); check("R3 command after program", v, 16'h0089);
    wr(0, 16'h00FF);
    rd(6, v); check("R3 second word", v, 16'h5678);
    rd(5, v, 1'b1); check("R12 odd bus address same word", v, 16'h1234);
    wr(7, 16'h0040, 1'b1);
    wr(7, 16'hBEEF, 1'b1);
    wr(0, 16'h00FF);
    rd(7, v); check("R12 write via odd address", v, 16'hBEEF);
  endtask

  task automatic t_buffer();
    logic [15:0] v;
    wr(16, 16'h00E8);
    rd(0, v); check("R14 count phase ready", v, 16'h0080);
    wr(99, 16'hFFE3);  // low 5 bits 3 -> 4 words
    wr(40, 16'hDEAD);  // outside window
    wr(20, 16'hDEAD);  // just past window
    wr(17, 16'hA001);
    wr(16, 16'hA000);
    wr(19, 16'hA003);
    rd(0, v); check("R14 data phase ready", v, 16'h0080);
    wr(18, 16'hA002);
    rd(0, v); check("R14 confirm phase ready", v, 16'h0080);
    wr(3, 16'h11D0);
    rd(16, v); check("R6 commit slot 0", v, 16'hA000);
    rd(17, v); check("R6 commit slot 1", v, 16'hA001);
    rd(18, v); check("R6 commit slot 2", v, 16'hA002);
    rd(19, v); check("R6 commit slot 3", v, 16'hA003);
    rd(40, v); check("R5 outside write dropped", v, 16'hFFFF);
    rd(20, v); check("R5 edge write dropped", v, 16'hFFFF);
    wr(32, 16'h00E8);
    wr(32, 16'h0000);  // one word
    wr(32, 16'h7777);
    wr(32, 16'h00AA);  // not confirm
    rd(32, v); check("R6 discard keeps array", v, 16'hFFFF);
    wr(48, 16'h00E8);
    wr(48, 16'h001F);  // 32 words
    for (int i = 0; i < 32; i++) wr(48 + i, 16'(16'hC000 + i));
    wr(0, 16'h00D0);
    rd(48, v); check("R4 32-word first", v, 16'hC000);
    rd(79, v); check("R4 32-word last", v, 16'hC01F);
  endtask

  task automatic t_erase();
    logic [15:0] v;
    wr(260, 16'h0040); wr(260, 16'h0101); wr(0, 16'h00FF);
    wr(300, 16'h0020);
    wr(300, 16'h0011);
    rd(0, v); check("R8 still armed reads ready", v, 16'h0080);
    rd(260, v); check("R8 no erase yet", v, 16'h0080);
    wr(300, 16'h00D0);
    rd(0, v); check("R7 erase-done ready", v, 16'h0080);
    wr(0, 16'h00FF);
    rd(260, v); check("R7 block erased", v, 16'hFFFF);
    rd(5, v); check("R7 other block kept", v, 16'h1234);
    wr(10, 16'h0020); wr(10, 16'h00D0);
    wr(0, 16'h0090);  // command in erase-done
    rd(1, v); check("R7 command after erase", v, 16'h00A0);
    wr(0, 16'h00FF);
    rd(16, v); check("R7 block 0 erased", v, 16'hFFFF);
    rd(260, v); check("R7 block 1 untouched", v, 16'hFFFF);
  endtask

  task automatic t_status_id();
    logic [15:0] v;
    wr(0, 16'h0040); wr(5, 16'h1234); wr(0, 16'h00FF);
    wr(0, 16'h0070);
    rd(0, v); check("R9 status read", v, 16'h0080);
    rd(5, v); check("R9 back to array", v, 16'h1234);
    wr(0, 16'h0070);
    wr(5, 16'h0040);  // consumed, not decoded
    rd(5, v); check("R9 write not decoded", v, 16'h1234);
    wr(0, 16'h0090); wr(0, 16'h0050);
    rd(5, v); check("R10 clear returns array", v, 16'h1234);
    wr(0, 16'h0090); wr(0, 16'h00FF);
    rd(5, v); check("R10 FF returns array", v, 16'h1234);
    wr(0, 16'h0090);
    rd(0, v); check("R11 manufacturer", v, 16'h0089);
    rd(1, v); check("R11 device code", v, 16'h00A0);
    rd(2, v); check("R11 other address", v, 16'h0000);
    wr(0, 16'h0040); wr(8, 16'h4321); wr(0, 16'h00FF);
    rd(8, v); check("R11 write decoded in id mode", v, 16'h4321);
  endtask

  task automatic t_unknown();
    logic [15:0] v;
    wr(0, 16'h0033);
    check("R13 error pulse", {15'b0, err_seen}, 16'h1);
    check("R13 pulse one cycle", {15'b0, err_after}, 16'h0);
    rd(5, v); check("R13 array mode kept", v, 16'h1234);
    wr(0, 16'h0090);
    check("R13 no error on known", {15'b0, err_seen}, 16'h0);
    wr(0, 16'h00C3);
    check("R13 error in id mode", {15'b0, err_seen}, 16'h1);
    rd(0, v); check("R13 id mode kept", v, 16'h0089);
    wr(0, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_buffer();
    t_erase();
    t_status_id();
    t_unknown();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule